// File: doc/BRIEF.md
# APB Address-Decoding Single-Requester Interconnect

This block joins one APB4 requester to a fixed number of memory-mapped completer ports. The incoming address is compared against a per-slot table of inclusive base and bound addresses, set by parameters at elaboration. The comparison yields a one-hot target vector, and only the target completer has its select raised. Address, protection, enable, direction, write data and byte strobes are copied unchanged to every completer port. The ready, read data and error response of the chosen completer are returned to the requester.

Each slot carries an access policy. The 2-bit policy codes are 0 for an error sink, 1 for read-only, 2 for write-only and 3 for read-write. An address that hits no range is steered to the lowest-numbered error slot. An access that breaks the target slot's policy is not passed on either. In both cases the interconnect completes the transfer itself with an error response. The target is worked out combinationally in the setup phase and captured at the clock edge that ends it. The access phase then uses the captured target, so the return multiplexer is driven from a register.

Top module: `apbx_interconnect`

## Requirements
- R1: With the default map (slot 0 read-write at 0x0000–0x0FFF, slot 1 read-only at 0x1000–0x1FFF, slot 2 write-only at 0x2000–0x2FFF, slot 3 error), a permitted access whose address lies inside slot i's inclusive range raises bit i of `cp_psel` in both the setup and the access phase. Bit i of `cp_psel` is the select of completer i.
- R2: At most one bit of `cp_psel` is high in any cycle.
- R3: Completer port i carries address, protection, enable, direction, write data and strobes equal to the requester's, in field i of each packed output (bits i*W upward).
- R4: While a completer is selected, `rq_pready`, `rq_prdata` and `rq_pslverr` equal that completer's ready, data (field i of `cp_prdata`) and error inputs, including wait states.
- R5: An address that matches no range raises no completer select. In the access phase the requester sees ready=1, error=1 and data=0. In the setup phase it sees ready=0 and error=0.
- R6: A write to a read-only slot raises no completer select and completes in the access phase with ready=1, error=1 and data=0.
- R7: A read from a write-only slot raises no completer select and completes in the access phase with ready=1, error=1 and data=0.
- R8: While `rq_psel` is low, and during reset, all of `cp_psel`, `rq_pready`, `rq_pslverr` and `rq_prdata` are zero.
- R9: The target captured at the end of the setup phase is held for the whole access phase. An address change during the access phase does not move the completer select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | clock |
| presetn | input | 1 | asynchronous active-low reset |
| rq_psel | input | 1 | requester select |
| rq_penable | input | 1 | requester enable (access phase) |
| rq_pwrite | input | 1 | requester direction, 1 = write |
| rq_paddr | input | ADDR_W | requester address |
| rq_pprot | input | 3 | requester protection attributes |
| rq_pwdata | input | DATA_W | requester write data |
| rq_pstrb | input | DATA_W/8 | requester byte strobes |
| rq_pready | output | 1 | ready returned to requester |
| rq_prdata | output | DATA_W | read data returned to requester |
| rq_pslverr | output | 1 | error returned to requester |
| cp_psel | output | N_SLOTS | per-completer select |
| cp_penable | output | N_SLOTS | per-completer enable |
| cp_pwrite | output | N_SLOTS | per-completer direction |
| cp_paddr | output | N_SLOTS*ADDR_W | per-completer address, packed |
| cp_pprot | output | N_SLOTS*3 | per-completer protection, packed |
| cp_pwdata | output | N_SLOTS*DATA_W | per-completer write data, packed |
| cp_pstrb | output | N_SLOTS*DATA_W/8 | per-completer strobes, packed |
| cp_pready | input | N_SLOTS | completer ready inputs |
| cp_prdata | input | N_SLOTS*DATA_W | completer read data, packed |
| cp_pslverr | input | N_SLOTS | completer error inputs |

## Verification
The address space is swept at a coarse stride, and every range's first and last address is added along with the first address past each range and the top of the space. Each address is tried as both a read and a write. This separates correct range decode from off-by-one bound errors, and policy blocking from plain forwarding, since the same slot must forward one direction and refuse the other. Each completer returns data that encodes its own index and the address, and raises its error only at one address. A mis-routed return path or a masked completer error therefore shows up at once. A stalled completer with an address change during its access phase separates a held target from one decoded again each cycle.

// File: rtl/apbx_pkg.sv
package apbx_pkg;
  typedef enum logic [1:0] {
    POL_ERR = 2'd0,
    POL_RO  = 2'd1,
    POL_WO  = 2'd2,
    POL_RW  = 2'd3
  } apbx_pol_e;

  localparam int unsigned PROT_W = 3;
endpackage

// File: rtl/apbx_addr_decode.sv
module apbx_addr_decode
  import apbx_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned ADDR_W  = 16,
  parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_BASE  = '0,
  parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_BOUND = '0,
  parameter logic [N_SLOTS*2-1:0]      SLOT_POLICY = '0
) (
  input  logic [ADDR_W-1:0]  paddr,
  input  logic               pwrite,
  output logic [N_SLOTS-1:0] tgt,
  output logic               blk
);
  logic [N_SLOTS-1:0] hit;
  logic [N_SLOTS-1:0] is_err;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    localparam logic [1:0]        POL = SLOT_POLICY[2*g +: 2];
    localparam logic [ADDR_W-1:0] LO  = SLOT_BASE[ADDR_W*g +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI  = SLOT_BOUND[ADDR_W*g +: ADDR_W];
    if (POL == POL_ERR) begin : g_err
      assign is_err[g] = 1'b1;
      assign hit[g]    = 1'b0;
    end else begin : g_rng
      assign is_err[g] = 1'b0;
      assign hit[g]    = (paddr >= LO) && (paddr <= HI);
    end
  end

  logic       found;
  logic [1:0] tgt_pol;

  always_comb begin
    tgt   = '0;
    found = 1'b0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (hit[i] && !found) begin
        tgt[i] = 1'b1;
        found  = 1'b1;
      end
    end
    for (int i = 0; i < N_SLOTS; i++) begin
      if (is_err[i] && !found) begin
        tgt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    tgt_pol = 2'd0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (tgt[i]) tgt_pol = tgt_pol | SLOT_POLICY[2*i +: 2];
    end
    blk = (tgt_pol == POL_ERR)
       || ((tgt_pol == POL_RO) &&  pwrite)
       || ((tgt_pol == POL_WO) && !pwrite);
  end
endmodule

// File: rtl/apbx_sel_hold.sv
module apbx_sel_hold #(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               use_held,
  input  logic [N_SLOTS-1:0] tgt_in,
  input  logic               blk_in,
  output logic [N_SLOTS-1:0] tgt_out,
  output logic               blk_out
);
  logic [1:0]         rs_q;
  logic               rst_int_n;
  logic [N_SLOTS-1:0] tgt_d, tgt_q;
  logic               blk_d, blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    tgt_d = tgt_q;
    blk_d = blk_q;
    if (capture) begin
      tgt_d = tgt_in;
      blk_d = blk_in;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tgt_q <= '0;
      blk_q <= 1'b1;
    end else begin
      tgt_q <= tgt_d;
      blk_q <= blk_d;
    end
  end

  assign tgt_out = use_held ? tgt_q : tgt_in;
  assign blk_out = use_held ? blk_q : blk_in;
endmodule

// File: rtl/apbx_resp_mux.sv
module apbx_resp_mux #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [N_SLOTS-1:0]        fwd,
  input  logic                      internal,
  input  logic                      penable,
  input  logic [N_SLOTS-1:0]        cp_pready,
  input  logic [N_SLOTS*DATA_W-1:0] cp_prdata,
  input  logic [N_SLOTS-1:0]        cp_pslverr,
  output logic                      pready,
  output logic [DATA_W-1:0]         prdata,
  output logic                      pslverr
);
  always_comb begin
    pready  = 1'b0;
    pslverr = 1'b0;
    prdata  = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (fwd[i]) begin
        pready  = pready  | cp_pready[i];
        pslverr = pslverr | cp_pslverr[i];
        prdata  = prdata  | cp_prdata[i*DATA_W +: DATA_W];
      end
    end
    if (internal) begin
      pready  = penable;
      pslverr = penable;
      prdata  = '0;
    end
  end
endmodule

// File: rtl/apbx_interconnect.sv
module apbx_interconnect
  import apbx_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 32,
  parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_BASE  = {16'h0000, 16'h2000, 16'h1000, 16'h0000},
  parameter logic [N_SLOTS*ADDR_W-1:0] SLOT_BOUND = {16'h0000, 16'h2FFF, 16'h1FFF, 16'h0FFF},
  parameter logic [N_SLOTS*2-1:0]      SLOT_POLICY = {POL_ERR, POL_WO, POL_RO, POL_RW},
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        rq_psel,
  input  logic                        rq_penable,
  input  logic                        rq_pwrite,
  input  logic [ADDR_W-1:0]           rq_paddr,
  input  logic [PROT_W-1:0]           rq_pprot,
  input  logic [DATA_W-1:0]           rq_pwdata,
  input  logic [STRB_W-1:0]           rq_pstrb,
  output logic                        rq_pready,
  output logic [DATA_W-1:0]           rq_prdata,
  output logic                        rq_pslverr,
  output logic [N_SLOTS-1:0]          cp_psel,
  output logic [N_SLOTS-1:0]          cp_penable,
  output logic [N_SLOTS-1:0]          cp_pwrite,
  output logic [N_SLOTS*ADDR_W-1:0]   cp_paddr,
  output logic [N_SLOTS*PROT_W-1:0]   cp_pprot,
  output logic [N_SLOTS*DATA_W-1:0]   cp_pwdata,
  output logic [N_SLOTS*STRB_W-1:0]   cp_pstrb,
  input  logic [N_SLOTS-1:0]          cp_pready,
  input  logic [N_SLOTS*DATA_W-1:0]   cp_prdata,
  input  logic [N_SLOTS-1:0]          cp_pslverr
);
  logic               setup_ph, access_ph;
  logic [N_SLOTS-1:0] dec_tgt, act_tgt, fwd;
  logic               dec_blk, act_blk, internal;

  assign setup_ph  = rq_psel && !rq_penable;
  assign access_ph = rq_psel &&  rq_penable;

  apbx_addr_decode #(
    .N_SLOTS    (N_SLOTS),
    .ADDR_W     (ADDR_W),
    .SLOT_BASE  (SLOT_BASE),
    .SLOT_BOUND (SLOT_BOUND),
    .SLOT_POLICY(SLOT_POLICY)
  ) u_dec (
    .paddr (rq_paddr),
    .pwrite(rq_pwrite),
    .tgt   (dec_tgt),
    .blk   (dec_blk)
  );

  apbx_sel_hold #(.N_SLOTS(N_SLOTS)) u_hold (
    .clk     (pclk),
    .rst_n   (presetn),
    .capture (setup_ph),
    .use_held(access_ph),
    .tgt_in  (dec_tgt),
    .blk_in  (dec_blk),
    .tgt_out (act_tgt),
    .blk_out (act_blk)
  );

  assign fwd      = (rq_psel && !act_blk) ? act_tgt : '0;
  assign internal = rq_psel && act_blk;
  assign cp_psel  = fwd;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_bcast
    assign cp_penable[g]                   = rq_penable;
    assign cp_pwrite[g]                    = rq_pwrite;
    assign cp_paddr[g*ADDR_W +: ADDR_W]    = rq_paddr;
    assign cp_pprot[g*PROT_W +: PROT_W]    = rq_pprot;
    assign cp_pwdata[g*DATA_W +: DATA_W]   = rq_pwdata;
    assign cp_pstrb[g*STRB_W +: STRB_W]    = rq_pstrb;
  end

  apbx_resp_mux #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_rsp (
    .fwd       (fwd),
    .internal  (internal),
    .penable   (rq_penable),
    .cp_pready (cp_pready),
    .cp_prdata (cp_prdata),
    .cp_pslverr(cp_pslverr),
    .pready    (rq_pready),
    .prdata    (rq_prdata),
    .pslverr   (rq_pslverr)
  );
endmodule

// File: rtl/apbx_interconnect_chk.sv
module apbx_interconnect_chk
  import apbx_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [N_SLOTS*2-1:0] SLOT_POLICY = '0
) (
  input logic               pclk,
  input logic               presetn,
  input logic               rq_psel,
  input logic               rq_penable,
  input logic               rq_pwrite,
  input logic               rq_pready,
  input logic [DATA_W-1:0]  rq_prdata,
  input logic               rq_pslverr,
  input logic [N_SLOTS-1:0] cp_psel,
  input logic [N_SLOTS-1:0] cp_pready
);
  p_onehot_sel_r2: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(cp_psel));

  p_idle_quiet_r8: assert property (@(posedge pclk) disable iff (!presetn)
    !rq_psel |-> (cp_psel == '0 && !rq_pready && !rq_pslverr && rq_prdata == '0));

  p_local_err_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (rq_psel && rq_penable && cp_psel == '0) |-> (rq_pready && rq_pslverr && rq_prdata == '0));

  p_ready_route_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (rq_psel && cp_psel != '0) |-> (rq_pready == |(cp_psel & cp_pready)));

  p_held_sel_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (rq_psel && rq_penable && $past(rq_psel)) |-> $stable(cp_psel));

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_pol
    if (SLOT_POLICY[2*g +: 2] == POL_RO) begin : g_ro
      p_ro_no_write_r6: assert property (@(posedge pclk) disable iff (!presetn)
        rq_pwrite |-> !cp_psel[g]);
    end
    if (SLOT_POLICY[2*g +: 2] == POL_WO) begin : g_wo
      p_wo_no_read_r7: assert property (@(posedge pclk) disable iff (!presetn)
        !rq_pwrite |-> !cp_psel[g]);
    end
  end
endmodule

bind apbx_interconnect apbx_interconnect_chk #(
  .N_SLOTS    (N_SLOTS),
  .DATA_W     (DATA_W),
  .SLOT_POLICY(SLOT_POLICY)
) u_chk (
  .pclk      (pclk),
  .presetn   (presetn),
  .rq_psel   (rq_psel),
  .rq_penable(rq_penable),
  .rq_pwrite (rq_pwrite),
  .rq_pready (rq_pready),
  .rq_prdata (rq_prdata),
  .rq_pslverr(rq_pslverr),
  .cp_psel   (cp_psel),
  .cp_pready (cp_pready)
);

// File: tb/apbx_interconnect_tb.sv
module apbx_interconnect_tb;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic          pclk = 1'b0;
  logic          presetn;
  logic          rq_psel, rq_penable, rq_pwrite;
  logic [AW-1:0] rq_paddr;
  logic [2:0]    rq_pprot;
  logic [DW-1:0] rq_pwdata;
  logic [SW-1:0] rq_pstrb;
  logic          rq_pready, rq_pslverr;
  logic [DW-1:0] rq_prdata;
  logic [N-1:0]  cp_psel, cp_penable, cp_pwrite;
  logic [N*AW-1:0] cp_paddr;
  logic [N*3-1:0]  cp_pprot;
  logic [N*DW-1:0] cp_pwdata;
  logic [N*SW-1:0] cp_pstrb;
  logic [N-1:0]    cp_pready, cp_pslverr;
  logic [N*DW-1:0] cp_prdata;
  logic [N-1:0]    stall;

  int checks = 0;
  int errors = 0;

  always #2 pclk = ~pclk;

  apbx_interconnect u_dut (.*);

  function automatic logic [DW-1:0] mdl_data(int i, logic [AW-1:0] a);
    return {8'hC0 | 8'(i), 8'h5A, a};
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cp_pready[i]           = ~stall[i];
      cp_pslverr[i]          = (cp_paddr[i*AW +: 12] == 12'hFFC);
      cp_prdata[i*DW +: DW]  = mdl_data(i, cp_paddr[i*AW +: AW]);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slot_of(logic [AW-1:0] a);
    if (a < 16'h1000) return 0;
    if (a < 16'h2000) return 1;
    if (a < 16'h3000) return 2;
    return 3;
  endfunction

  task automatic xfer(input logic [AW-1:0] a, input logic wr);
    int s, k;
    bit blocked;
    logic [N-1:0] exp_sel;
    string tag;
    s = slot_of(a);
    blocked = (s == 3) || (s == 1 && wr) || (s == 2 && !wr);
    exp_sel = blocked ? '0 : (N'(1) << s);
    tag = (s == 3) ? "R5" : (s == 1 && wr) ? "R6" : (s == 2 && !wr) ? "R7" : "R1";
    k = int'(a[11:10]);
    @(negedge pclk);
    rq_psel = 1'b1; rq_penable = 1'b0; rq_pwrite = wr; rq_paddr = a;
    rq_pprot = a[2:0]; rq_pwdata = {~a, a}; rq_pstrb = a[3:0];
    #1;
    chk(cp_psel == exp_sel, {tag, " setup select"}, 64'(cp_psel), 64'(exp_sel));
    if (blocked) chk(!rq_pready && !rq_pslverr, "R5 setup response quiet",
                     64'({rq_pready, rq_pslverr}), 64'd0);
    @(negedge pclk);
    rq_penable = 1'b1;
    #1;
    chk(cp_psel == exp_sel, {tag, " access select"}, 64'(cp_psel), 64'(exp_sel));
    chk($countones(cp_psel) <= 1, "R2 one-hot", 64'(cp_psel), 64'(exp_sel));
    chk(cp_paddr[k*AW +: AW] == a && cp_pwdata[k*DW +: DW] == {~a, a} &&
        cp_pstrb[k*SW +: SW] == a[3:0] && cp_pprot[k*3 +: 3] == a[2:0] &&
        cp_pwrite[k] == wr && cp_penable[k] == 1'b1,
        "R3 broadcast", 64'(cp_paddr[k*AW +: AW]), 64'(a));
    if (blocked) begin
      chk(rq_pready && rq_pslverr && rq_prdata == '0, {tag, " local error"},
          64'({rq_pready, rq_pslverr, rq_prdata}), 64'({2'b11, 32'h0}));
    end else begin
      chk(rq_pready && rq_prdata == mdl_data(s, a) && rq_pslverr == (a[11:0] == 12'hFFC),
          "R4 forwarded response", 64'({rq_pready, rq_pslverr, rq_prdata}),
          64'({1'b1, (a[11:0] == 12'hFFC), mdl_data(s, a)}));
    end
    @(negedge pclk);
    rq_psel = 1'b0; rq_penable = 1'b0;
    #1;
    chk(cp_psel == '0 && !rq_pready && !rq_pslverr && rq_prdata == '0, "R8 idle",
        64'({cp_psel, rq_pready, rq_pslverr, rq_prdata}), 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge pclk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] edges [12];
    edges = '{16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'h2FFF, 16'h3000,
              16'hFFFF, 16'h0FFC, 16'h1FFC, 16'h2FFC, 16'h0000, 16'h3FFC};
    presetn = 1'b0; stall = '0;
    rq_psel = 1'b0; rq_penable = 1'b0; rq_pwrite = 1'b0;
    rq_paddr = '0; rq_pprot = '0; rq_pwdata = '0; rq_pstrb = '0;
    repeat (3) @(negedge pclk);
    chk(cp_psel == '0 && !rq_pready && !rq_pslverr && rq_prdata == '0, "R8 reset state",
        64'({cp_psel, rq_pready, rq_pslverr, rq_prdata}), 64'd0);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);

    for (int a = 0; a < 65536; a += 1024) begin
      xfer(AW'(a), 1'b0);
      xfer(AW'(a), 1'b1);
    end
    foreach (edges[e]) begin
      xfer(edges[e], 1'b0);
      xfer(edges[e], 1'b1);
    end

    // R9 and R4 wait states: stalled slot 0, address moved mid-access
    stall[0] = 1'b1;
    @(negedge pclk);
    rq_psel = 1'b1; rq_penable = 1'b0; rq_pwrite = 1'b0; rq_paddr = 16'h0040;
    @(negedge pclk);
    rq_penable = 1'b1;
    #1;
    chk(!rq_pready, "R4 wait state", 64'(rq_pready), 64'd0);
    @(negedge pclk);
    rq_paddr = 16'h2040;
    #1;
    chk(cp_psel == 4'b0001, "R9 held select", 64'(cp_psel), 64'h1);
    chk(!rq_pready && !rq_pslverr, "R9 no local error", 64'({rq_pready, rq_pslverr}), 64'd0);
    @(negedge pclk);
    stall[0] = 1'b0;
    #1;
    chk(rq_pready && cp_psel == 4'b0001 && rq_prdata == mdl_data(0, 16'h2040),
        "R9 completes on held slot", 64'({cp_psel, rq_pready, rq_prdata}),
        64'({4'b0001, 1'b1, mdl_data(0, 16'h2040)}));
    @(negedge pclk);
    rq_psel = 1'b0; rq_penable = 1'b0;
    #1;
    chk(cp_psel == '0 && !rq_pready, "R8 idle after stall", 64'({cp_psel, rq_pready}), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule